// File: doc/BRIEF.md
# Serial Flash Transaction Sequencer

This block runs one serial-flash transaction at a time. Software fills a few configuration registers, places any outgoing payload in a transmit FIFO, and then writes a command word. Writing the command word launches the sequence. The sequence has four phases: an 8-bit opcode, an optional address, optional dummy clocks, and a data phase of any byte count from 0 to 16383. Payload moves through 32-bit transmit and receive FIFOs. The opcode and address always travel on one line. Only the data phase can widen to two or four lines.

The serial clock is the system clock divided by a fixed parameter, in SPI mode 0: the clock idles low, outputs change after a falling edge, and inputs are sampled on the rising edge. Chip select stays low for the whole transaction. The block shows its progress through a busy flag, a FIFO status word and a set of sticky raw interrupt bits. Software clears those bits by writing ones to a clear register. A self-clearing recovery bit aborts a transfer and empties both FIFOs.

Register index map on `reg_addr`:

| Index | Write effect | Read value |
|---|---|---|
| 0 | control | control |
| 1 | command (launches a transfer) | command |
| 2 | address | address |
| 3 | variable address length | variable address length |
| 4 | interrupt clear | raw interrupts |
| 5 | recovery | recovery |
| 6 | none | FIFO status |
| 7 | none | busy |

Top module: `flash_xfer_seq`

## Requirements
- R1: A write to command index 1 while idle starts a transfer. `cs_n` goes low and `sclk` idles low whenever `cs_n` is high. The 8 opcode bits (command bits 7:0) go out MSB first on io[0] with io_oe = 4'b0001, one bit per rising `sclk` edge.
- R2: Address mode is set by command bits 15:14. Mode 0 skips the address phase. Mode 1 sends 24 address bits, mode 2 sends 32, and mode 3 sends (index 3 bits 4:0) + 1 bits. In every mode the bits are the low bits of the address register, sent MSB first on io[0] with io_oe = 4'b0001.
- R3: Command bits 11:8 give a number of dummy clocks, during which `sclk` toggles and io_oe is 0.
- R4: Control bits 13:12 set the data width: 0 = one line, 1 = two lines, 2 = four lines. On a write (command bit 12 = 1), one line uses io[0]; two lines use io[1:0] with io[1] carrying the higher bit; four lines use io[3:0] with io[3] carrying the higher bit. On a read (bit 12 = 0), io_oe is 0 and the block samples io[1] (one line), io[1:0] (two lines) or io[3:0] (four lines).
- R5: Command bits 29:16 give the byte count. Each FIFO word is used lowest byte first, and each byte goes out MSB first. A final partial word uses only its low bytes. A received partial word holds its bytes in the low bytes, with the upper bytes zero.
- R6: A byte count of zero gives the opcode, address and dummy phases only, then finishes.
- R7: Writes to indices 0 to 3 and command writes are ignored while busy.
- R8: FIFO status (index 6, also the `fifo_status` port) has tx-full in bit 0, tx-empty in bit 1, rx-empty in bit 2 and rx-full in bit 3. The tx level is in bits 12:8 and the rx level in bits 20:16. Each FIFO holds 16 words. Pushing to a full tx FIFO drops the word.
- R9: Raw interrupt bits are sticky. Bit 0 sets when the rx FIFO becomes full, bit 1 on a pop of an empty rx FIFO, bit 2 on a push to a full tx FIFO, bit 3 when the engine empties the tx FIFO, and bit 4 on transfer finish. Writing a 1 to a bit at index 4 clears it.
- R10: Writing 1 to bit 0 of index 5 makes that bit read 1 for one cycle. In that cycle the block aborts any transfer and empties both FIFOs, after which the bit reads 0.
- R11: When a transfer ends normally, `busy` drops, `cs_n` rises and raw bit 4 is set.
- R12: When a write transfer needs a new word and the tx FIFO is empty, the block holds `sclk` low with `cs_n` asserted. It resumes once a word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| tx_push | input | 1 | push `tx_data` into the transmit FIFO |
| tx_data | input | 32 | transmit word |
| rx_pop | input | 1 | pop the receive FIFO head |
| rx_data | output | 32 | receive FIFO head word |
| busy | output | 1 | transfer in progress |
| fifo_status | output | 32 | FIFO status word |
| raw_irq | output | 8 | sticky raw interrupt bits |
| sclk | output | 1 | serial clock |
| cs_n | output | 1 | active-low chip select |
| io_out | output | 4 | I/O line output values |
| io_oe | output | 4 | I/O line output enables |
| io_in | input | 4 | I/O line input values |

## Verification
The bench records every rising serial clock edge and compares each slot with a bench-built expectation. That exposes an address length off by one in variable mode, dummy clocks that still drive the bus, or a reversed line order in two- or four-line mode. It also exposes a wrong byte order inside a word, including the partial final word. Read data comes from a slot-indexed pattern, so a sampling edge shifted by one slot, or the wrong input line in one-line mode, shows up as a wrong received word. Directed cases cover a zero byte count, a control write made during a transfer, tx FIFO overflow followed by recovery, rx underflow, an rx FIFO that fills exactly, and a write that runs out of tx data mid-transfer, where a faulty design would clock out garbage or finish early.

// File: rtl/flash_xfer_seq.sv
module flash_xfer_seq #(
  parameter int FIFO_DEPTH = 16,
  parameter int SCLK_DIV   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_push,
  input  logic [31:0] tx_data,
  input  logic        rx_pop,
  output logic [31:0] rx_data,
  output logic        busy,
  output logic [31:0] fifo_status,
  output logic [7:0]  raw_irq,
  output logic        sclk,
  output logic        cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int DW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);
  localparam logic [DW-1:0] DIV_LAST = DW'(SCLK_DIV - 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(FIFO_DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_DMY, S_DAT} st_t;

  logic [13:0] ctrl_r;
  logic [31:0] cmd_r, addr_r;
  logic [4:0]  alen_r, ri;
  logic        rec;
  st_t         st;
  logic        sclk_r;
  logic [DW-1:0] div_cnt;
  logic [5:0]  bitcnt;
  logic [31:0] sh_out, word_rd, rx_acc;
  logic        need_word;
  logic [13:0] bytes_left;
  logic [1:0]  bidx;
  logic [3:0]  bslot;
  logic [7:0]  byte_sh;

  logic [31:0] tx_mem [FIFO_DEPTH];
  logic [31:0] rx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PW'(1);
  endfunction

  wire [3:0]  c_dummy = cmd_r[11:8];
  wire        c_wr    = cmd_r[12];
  wire [1:0]  c_am    = cmd_r[15:14];
  wire [13:0] c_cnt   = cmd_r[29:16];
  wire        quad    = ctrl_r[13:12] == 2'd2;
  wire        dual    = ctrl_r[13:12] == 2'd1;
  wire [3:0]  spb     = quad ? 4'd2 : (dual ? 4'd4 : 4'd8);
  wire [2:0]  wsh     = quad ? 3'd4 : (dual ? 3'd2 : 3'd1);

  logic [5:0] abits;
  always_comb
    case (c_am)
      2'd0: abits = 6'd0;
      2'd1: abits = 6'd24;
      2'd2: abits = 6'd32;
      default: abits = {1'b0, alen_r} + 6'd1;
    endcase

  assign busy = st != S_IDLE;
  wire  st_after_dmy = 1'b0;
  st_t  after_adr, after_opc, next_st;
  assign after_adr = (c_dummy != 0) ? S_DMY : ((c_cnt != 0) ? S_DAT : S_IDLE);
  assign after_opc = (c_am != 0) ? S_ADR : after_adr;
  always_comb
    case (st)
      S_OPC:   next_st = after_opc;
      S_ADR:   next_st = after_adr;
      S_DMY:   next_st = (c_cnt != 0) ? S_DAT : S_IDLE;
      default: next_st = S_IDLE;
    endcase

  wire running = busy && !(st == S_DAT && need_word) && !rec;
  wire tick = running && div_cnt == DIV_LAST;
  wire rise = tick && !sclk_r;
  wire fall = tick && sclk_r;
  wire last_slot = (st == S_DAT) ? (bytes_left == 14'd1 && bslot == 4'd1) : (bitcnt == 6'd1);
  wire done_ev = fall && last_slot && next_st == S_IDLE && !st_after_dmy;

  wire [7:0] rx_byte_nx = quad ? {byte_sh[3:0], io_in} :
                          dual ? {byte_sh[5:0], io_in[1:0]} : {byte_sh[6:0], io_in[1]};
  wire [31:0] rx_word_nx = rx_acc | ({24'b0, rx_byte_nx} << {bidx, 3'b0});
  wire [1:0]  bidx_n = bidx + 2'd1;
  wire [31:0] word_sh = word_rd >> {bidx_n, 3'b0};

  wire start   = reg_we && reg_addr == 3'd1 && !busy && !rec;
  wire cfg_ok  = reg_we && !busy;
  wire word_go = st == S_DAT && need_word && !rec && (c_wr ? tx_cnt != 0 : rx_cnt != FULL);
  wire eng_pop = word_go && c_wr;
  wire eng_push = rise && st == S_DAT && !c_wr && bslot == 4'd1 && (bidx == 2'd3 || bytes_left == 14'd1);
  wire tx_ok = tx_push && tx_cnt != FULL;
  wire rx_ok = rx_pop && rx_cnt != 0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_r <= '0; addr_r <= '0; alen_r <= '0; ri <= '0; rec <= 1'b0;
    end else begin
      if (cfg_ok && reg_addr == 3'd0) ctrl_r <= reg_wdata[13:0];
      if (cfg_ok && reg_addr == 3'd2) addr_r <= reg_wdata;
      if (cfg_ok && reg_addr == 3'd3) alen_r <= reg_wdata[4:0];
      rec <= reg_we && reg_addr == 3'd5 && reg_wdata[0] && !rec;
      ri <= (ri & ~((reg_we && reg_addr == 3'd4) ? reg_wdata[4:0] : 5'd0)) |
            {done_ev,
             eng_pop && tx_cnt == CW'(1) && !tx_ok,
             tx_push && tx_cnt == FULL,
             rx_pop && rx_cnt == 0,
             eng_push && rx_cnt == FULL - CW'(1) && !rx_ok};
    end

  always_ff @(posedge clk) begin
    if (tx_ok) tx_mem[tx_wp] <= tx_data;
    if (eng_push) rx_mem[rx_wp] <= rx_word_nx;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rec) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_ok) tx_wp <= inc(tx_wp);
      if (eng_pop) tx_rp <= inc(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_ok) - CW'(eng_pop);
      if (eng_push) rx_wp <= inc(rx_wp);
      if (rx_ok) rx_rp <= inc(rx_rp);
      rx_cnt <= rx_cnt + CW'(eng_push) - CW'(rx_ok);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cmd_r <= '0; sclk_r <= 1'b0; div_cnt <= '0; bitcnt <= '0;
      sh_out <= '0; word_rd <= '0; rx_acc <= '0; need_word <= 1'b0;
      bytes_left <= '0; bidx <= '0; bslot <= '0; byte_sh <= '0;
    end else if (rec) begin
      st <= S_IDLE; sclk_r <= 1'b0; div_cnt <= '0; need_word <= 1'b0;
    end else if (start) begin
      st <= S_OPC; cmd_r <= reg_wdata; sh_out <= {reg_wdata[7:0], 24'b0};
      bitcnt <= 6'd8; sclk_r <= 1'b0; div_cnt <= '0;
    end else if (busy) begin
      if (word_go) begin
        need_word <= 1'b0; bidx <= '0; bslot <= spb; rx_acc <= '0;
        if (c_wr) begin
          word_rd <= tx_mem[tx_rp];
          byte_sh <= tx_mem[tx_rp][7:0];
        end
      end
      if (running) div_cnt <= tick ? '0 : div_cnt + DW'(1);
      if (rise) begin
        sclk_r <= 1'b1;
        if (st == S_DAT && !c_wr) begin
          byte_sh <= rx_byte_nx;
          if (bslot == 4'd1) rx_acc <= rx_word_nx;
        end
      end
      if (fall) begin
        sclk_r <= 1'b0;
        if (last_slot) begin
          st <= next_st;
          bitcnt <= (next_st == S_ADR) ? abits : {2'b0, c_dummy};
          sh_out <= addr_r << (6'd32 - abits);
          need_word <= 1'b1;
          bytes_left <= c_cnt;
        end else
          case (st)
            S_OPC, S_ADR: begin sh_out <= sh_out << 1; bitcnt <= bitcnt - 6'd1; end
            S_DMY: bitcnt <= bitcnt - 6'd1;
            S_DAT: begin
              bslot <= bslot - 4'd1;
              if (c_wr) byte_sh <= byte_sh << wsh;
              if (bslot == 4'd1) begin
                bslot <= spb;
                bytes_left <= bytes_left - 14'd1;
                bidx <= bidx_n;
                if (c_wr) byte_sh <= word_sh[7:0];
                if (bidx == 2'd3) need_word <= 1'b1;
              end
            end
            default: ;
          endcase
      end
    end

  wire dat_wr = st == S_DAT && c_wr;
  assign io_oe  = (st == S_OPC || st == S_ADR) ? 4'b0001 :
                  dat_wr ? (quad ? 4'b1111 : dual ? 4'b0011 : 4'b0001) : 4'b0000;
  assign io_out = (st == S_OPC || st == S_ADR) ? {3'b0, sh_out[31]} :
                  dat_wr ? (quad ? byte_sh[7:4] : dual ? {2'b0, byte_sh[7:6]} : {3'b0, byte_sh[7]}) : 4'b0000;
  assign sclk = sclk_r;
  assign cs_n = !busy;
  assign rx_data = rx_mem[rx_rp];
  assign raw_irq = {3'b0, ri};

  wire [4:0] tx_lvl = 5'(tx_cnt);
  wire [4:0] rx_lvl = 5'(rx_cnt);
  assign fifo_status = {11'b0, rx_lvl, 3'b0, tx_lvl, 4'b0,
                        rx_cnt == FULL, rx_cnt == 0, tx_cnt == 0, tx_cnt == FULL};

  always_comb
    case (reg_addr)
      3'd0: reg_rdata = {18'b0, ctrl_r};
      3'd1: reg_rdata = cmd_r;
      3'd2: reg_rdata = addr_r;
      3'd3: reg_rdata = {27'b0, alen_r};
      3'd4: reg_rdata = {24'b0, raw_irq};
      3'd5: reg_rdata = {31'b0, rec};
      3'd6: reg_rdata = fifo_status;
      default: reg_rdata = {31'b0, busy};
    endcase

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R1
  AST_DUMMY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) st == S_DMY |-> io_oe == 4'b0000); // R3
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy && reg_we && reg_addr == 3'd0 |=> $stable(ctrl_r)); // R7
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL); // R8
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL); // R8
  AST_REC_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rec |=> !rec && tx_cnt == 0 && rx_cnt == 0 && !busy); // R10
  AST_FINISH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) && !$past(rec) |-> ri[4]); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) st == S_DAT && need_word |-> !sclk && !cs_n); // R12
endmodule

// File: tb/sim_flash_xfer_seq.sv
module sim_flash_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, tx_data = '0;
  logic [31:0] reg_rdata, rx_data, fifo_status;
  logic [7:0] raw_irq;
  logic busy, sclk, cs_n;
  logic [3:0] io_out, io_oe, io_in;

  flash_xfer_seq u0 (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .tx_push, .tx_data, .rx_pop, .rx_data, .busy, .fifo_status, .raw_irq,
    .sclk, .cs_n, .io_out, .io_oe, .io_in);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, nslot = 0;
  bit finished = 0;
  logic sclk_q = 1'b0;
  logic [3:0] log_out [1024];
  logic [3:0] log_oe  [1024];

  logic [7:0] t_op; logic [3:0] t_dm; logic t_wr; logic [1:0] t_am, t_wm;
  int t_cnt; logic [31:0] t_addr; logic [4:0] t_alen;
  logic [31:0] txw [16];

  function automatic logic [3:0] pat(int n);
    return 4'((n * 5 + (n >> 3) + 3) ^ (n >> 1));
  endfunction
  assign io_in = pat(nslot);

  always @(negedge clk) begin
    if (!cs_n && sclk && !sclk_q) begin
      if (nslot < 1024) begin log_out[nslot] = io_out; log_oe[nslot] = io_oe; end
      nslot = nslot + 1;
    end
    sclk_q = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d);
    tx_push = 1'b1; tx_data = d;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    d = rx_data; rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  function automatic int wb();
    return (t_wm == 2) ? 4 : ((t_wm == 1) ? 2 : 1);
  endfunction
  function automatic int ab();
    case (t_am)
      2'd0: return 0;
      2'd1: return 24;
      2'd2: return 32;
      default: return int'(t_alen) + 1;
    endcase
  endfunction
  function automatic int total_slots();
    return 8 + ab() + int'(t_dm) + t_cnt * (8 / wb());
  endfunction

  function automatic logic [7:0] exp_slot(int i);
    int base = 8 + ab() + int'(t_dm);
    int w = wb();
    int spb = 8 / w;
    if (i < 8) return {4'h1, 3'b0, t_op[7 - i]};
    if (i < 8 + ab()) return {4'h1, 3'b0, t_addr[ab() - 1 - (i - 8)]};
    if (i < base) return 8'h00;
    if (!t_wr) return 8'h00;
    begin
      int k = i - base;
      int b = k / spb;
      int s = k % spb;
      int mask = (1 << w) - 1;
      int bytev = int'((txw[b / 4] >> (8 * (b % 4))) & 32'hFF);
      int chunk = (bytev >> (8 - w * (s + 1))) & mask;
      return {4'(mask), 4'(chunk)};
    end
  endfunction

  function automatic logic [31:0] exp_rx(int wi);
    logic [31:0] word = '0;
    int w = wb();
    int spb = 8 / w;
    int base = 8 + ab() + int'(t_dm);
    for (int bb = 0; bb < 4; bb++) begin
      int b = wi * 4 + bb;
      if (b < t_cnt) begin
        int bytev = 0;
        for (int s = 0; s < spb; s++) begin
          int p = int'(pat(base + b * spb + s));
          int piece = (w == 4) ? p : ((w == 2) ? (p & 3) : ((p >> 1) & 1));
          bytev = ((bytev << w) | piece) & 8'hFF;
        end
        word = word | (32'(bytev) << (8 * bb));
      end
    end
    return word;
  endfunction

  task automatic start_xfer(input int npush);
    logic [31:0] d;
    wr(3'd4, 32'hFF);
    wr(3'd0, {18'b0, t_wm, 12'b0});
    wr(3'd2, t_addr);
    wr(3'd3, {27'b0, t_alen});
    for (int i = 0; i < npush; i++) push(txw[i]);
    nslot = 0;
    wr(3'd1, {2'b0, 14'(t_cnt), t_am, 1'b0, t_wr, t_dm, t_op});
    rd(3'd7, d);
  endtask

  task automatic finish_check(input bit expect_full);
    logic [31:0] d;
    int bad;
    string tag;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(nslot == total_slots(), "R2 slot count", 32'(nslot), 32'(total_slots()));
    bad = -1;
    for (int i = 0; i < total_slots() && i < 1024; i++) begin
      logic [7:0] e = exp_slot(i);
      if (bad < 0 && (log_oe[i] != e[7:4] || (log_out[i] & e[7:4]) != e[3:0])) bad = i;
    end
    if (bad < 0) chk(1'b1, "R1 slots", 0, 0);
    else begin
      logic [7:0] e = exp_slot(bad);
      tag = (bad < 8) ? "R1 opcode slot" : (bad < 8 + ab()) ? "R2 address slot" :
            (bad < 8 + ab() + int'(t_dm)) ? "R3 dummy slot" : "R4 R5 data slot";
      chk(1'b0, tag, {24'(bad), log_oe[bad], log_out[bad]}, {24'(bad), e});
    end
    rd(3'd4, d);
    chk(d[4] && cs_n, "R11 finish flag", d, d | 32'h10);
    if (!t_wr) begin
      int nw = (t_cnt + 3) / 4;
      rd(3'd6, d);
      chk(d[20:16] == 5'(nw), "R8 rx level", 32'(d[20:16]), 32'(nw));
      if (expect_full) begin
        rd(3'd4, d);
        chk(d[0] && fifo_status[3], "R9 rx full flag", d, 32'h1);
      end
      for (int i = 0; i < nw; i++) begin
        pop(d);
        chk(d == exp_rx(i), "R5 rx word", d, exp_rx(i));
      end
    end
    wr(3'd4, 32'h10);
    rd(3'd4, d);
    chk(d[4] == 1'b0, "R9 clear finish", d, d & ~32'h10);
  endtask

  task automatic run(input bit full);
    start_xfer(t_wr ? (t_cnt + 3) / 4 : 0);
    finish_check(full);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd6, d);
    chk(d == 32'h6, "R8 reset status", d, 32'h6);
    rd(3'd4, d);
    chk(d == 0, "R9 reset irq", d, 0);
    chk(cs_n && !sclk && !busy && io_oe == 0, "R1 reset pins", {cs_n, sclk, busy, io_oe}, 32'h40);

    // R6: opcode only, zero byte count
    t_op = 8'h05; t_dm = 0; t_wr = 0; t_am = 0; t_cnt = 0; t_wm = 0; t_addr = 0; t_alen = 0;
    run(0);

    // R2 R3 R5: variable address, dummy clocks, partial final word
    t_op = 8'h02; t_dm = 5; t_wr = 1; t_am = 3; t_cnt = 3; t_wm = 0; t_addr = 32'h0000_05A5; t_alen = 5'd10;
    txw[0] = 32'hC3_81_7E_19;
    run(0);

    // R7: configuration and command writes during a transfer are dropped
    t_op = 8'hEB; t_dm = 4; t_wr = 0; t_am = 2; t_cnt = 16; t_wm = 2; t_addr = 32'h1234_5678; t_alen = 0;
    start_xfer(0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0001_0003);
    rd(3'd0, d);
    chk(d == 32'h2000, "R7 control held", d, 32'h2000);
    finish_check(0);

    // R8 R9 R10: overflow then recovery
    for (int i = 0; i < 17; i++) push(32'(i));
    rd(3'd6, d);
    chk(d[0] && d[12:8] == 5'd16, "R8 tx full", d, 32'h1001);
    rd(3'd4, d);
    chk(d[2], "R9 tx overflow", d, 32'h4);
    wr(3'd5, 32'h1);
    rd(3'd5, d);
    chk(d == 1, "R10 recovery pending", d, 1);
    @(negedge clk);
    rd(3'd5, d);
    chk(d == 0, "R10 recovery done", d, 0);
    rd(3'd6, d);
    chk(d == 32'h6, "R10 fifos emptied", d, 32'h6);
    wr(3'd4, 32'hFF);

    // R9: rx underflow
    pop(d);
    rd(3'd4, d);
    chk(d[1], "R9 rx underflow", d, 32'h2);
    wr(3'd4, 32'hFF);

    // R8 R9: read fills rx FIFO exactly
    t_op = 8'h03; t_dm = 0; t_wr = 0; t_am = 1; t_cnt = 64; t_wm = 0; t_addr = 32'h00AB_CDEF; t_alen = 0;
    run(1);

    // R12: write stalls when tx runs dry
    t_op = 8'h32; t_dm = 0; t_wr = 1; t_am = 0; t_cnt = 8; t_wm = 0; t_addr = 0; t_alen = 0;
    txw[0] = 32'hDEAD_BEEF; txw[1] = 32'h0F1E_2D3C;
    start_xfer(1);
    repeat (300) @(negedge clk);
    chk(busy && !cs_n && !sclk && nslot == 40, "R12 stall hold", {busy, cs_n, sclk, 29'(nslot)}, 32'h8000_0028);
    rd(3'd4, d);
    chk(d[3], "R9 tx empty", d, 32'h8);
    push(txw[1]);
    finish_check(0);

    for (int r = 0; r < 20; r++) begin
      t_op = 8'($urandom); t_dm = 4'($urandom_range(0, 15)); t_wr = 1'($urandom);
      t_am = 2'($urandom_range(0, 3)); t_cnt = $urandom_range(0, 64); t_wm = 2'($urandom_range(0, 2));
      t_addr = $urandom; t_alen = 5'($urandom);
      for (int i = 0; i < 16; i++) txw[i] = $urandom;
      run(t_cnt == 64 && !t_wr);
    end

    e = 0;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail + int'(e));
    $finish;
  end
endmodule